// File: doc/BRIEF.md
# Serial Controller Interrupt Status Aggregator

This block collects the interrupt sources of a serial bus controller into one raw status word, gates that word with a software-owned enable mask, and drives a single interrupt line. Two kinds of source feed the raw word. The six FIFO condition bits follow live level inputs from the transmit and receive FIFOs. The nine bus and transaction event bits are set by one-cycle pulses. An event bit stays set until software writes a 1 to its position through the clear register.

Software reaches the block through a small register port with a two-bit address. Address 0 is the enable mask, which is read-write. Address 1 is the raw status, which is read-only. Address 2 is the masked status, which is read-only. Address 3 is the clear register, which is write-only. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is high.

Raw bit layout. Bit 0 is TX FIFO empty, bit 1 is TX FIFO nearly empty, bit 2 is TX FIFO full and bit 3 is TX overrun. Bit 4 is RX FIFO empty, bit 5 is RX FIFO nearly full and bit 6 is RX FIFO full. Bits 16 to 20 are, in order: slave read request, slave read empty, slave write request, master done and slave done. Bit 24 is arbitration lost, bit 25 is bus error and bit 28 is master done without stop.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the mask, raw and masked registers read 0 and `irq` is low.
- R2: A 1 on `evt_pulse` at an event position (3, 16–20, 24, 25 or 28) sets that raw bit at the next clock edge. The bit then stays set after the pulse has ended.
- R3: A write to address 3 clears every event raw bit whose position holds a 1 in `reg_wdata` and is also set in 0x131F007F. Event bits at positions written with 0 are unchanged.
- R4: If an event pulse and a clear of the same bit arrive in the same cycle, the bit is set after that edge.
- R5: Raw bits 0–2 take `fifo_lvl[2:0]` and raw bits 4–6 take `fifo_lvl[5:3]`, each one clock edge after the input. A write to the clear register has no effect on these bits.
- R6: A write to address 0 stores `reg_wdata & 0x1FFFFFFF`, so mask bits 31–29 always read 0.
- R7: Address 2 reads the raw status ANDed with the mask.
- R8: `irq` is the OR of all masked status bits, registered, so it follows a raw or mask change by one more clock edge.
- R9: Writes to address 1 or 2 change no register. Reading address 3 returns 0. Pulses at positions that are not event positions leave the raw status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_lvl | input | 6 | Live FIFO conditions: [2:0] TX empty, nearly empty, full; [5:3] RX empty, nearly full, full |
| evt_pulse | input | 32 | One-cycle event pulses at raw bit positions |
| reg_addr | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a clear write landing in the same cycle as a new pulse on the bit it clears. To produce it, one table row drives the pulse and a clear write at address 3 in a single cycle, and the raw word is read back afterwards. Other rows issue a clear with every bit set while FIFO levels are held high, which shows that level bits cannot be cleared and event bits can. Directed steps then walk the interrupt through its two-edge latency by changing the mask and the raw status separately.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int          DW       = 32,
  parameter logic [31:0] EVT_BITS = 32'h131F0008,
  parameter logic [31:0] CLR_BITS = 32'h131F007F,
  parameter logic [31:0] WR_BITS  = 32'h1FFFFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    fifo_lvl,
  input  logic [DW-1:0] evt_pulse,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam logic [1:0] A_MASK = 2'd0, A_RAW = 2'd1, A_MSK = 2'd2, A_CLR = 2'd3;

  logic [DW-1:0] mask_q, evt_q, lvl_q, raw, masked, clr_vec, lvl_map;

  assign lvl_map = {{(DW-7){1'b0}}, fifo_lvl[5:3], 1'b0, fifo_lvl[2:0]};
  assign clr_vec = (reg_wr && reg_addr == A_CLR) ? (reg_wdata & CLR_BITS) : '0;
  assign raw     = evt_q | lvl_q;
  assign masked  = raw & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      evt_q  <= '0;
      lvl_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata & WR_BITS;
      evt_q <= ((evt_q & ~clr_vec) | evt_pulse) & EVT_BITS;
      lvl_q <= lvl_map;
      irq   <= |masked;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_RAW:   reg_rdata = raw;
      A_MSK:   reg_rdata = masked;
      default: reg_rdata = '0;
    endcase
  end

  p_evt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(raw & EVT_BITS & ~clr_vec)) == $past(raw & EVT_BITS & ~clr_vec)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(evt_pulse & EVT_BITS)) == $past(evt_pulse & EVT_BITS)));

  p_lvl_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~EVT_BITS) == $past(lvl_map)));

  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[DW-1:DW-3] == 3'b000);

  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(raw & mask_q))));
endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int NV = 10;
  // {fifo_lvl[6], evt[32], wr[1], waddr[2], wdata[32], exp_raw[32]}
  localparam logic [104:0] VEC [NV] = '{
    {6'b000001, 32'h0,        1'b0, 2'd0, 32'h0,        32'h00000001},
    {6'b100000, 32'h00000008, 1'b0, 2'd0, 32'h0,        32'h00000048},
    {6'b000000, 32'h11000000, 1'b0, 2'd0, 32'h0,        32'h11000008},
    {6'b000000, 32'h0,        1'b1, 2'd3, 32'h00000008, 32'h11000000},
    {6'b000000, 32'h02000000, 1'b1, 2'd3, 32'h02000000, 32'h13000000},
    {6'b000000, 32'h00010000, 1'b1, 2'd3, 32'hFFFFFFFF, 32'h00010000},
    {6'b001000, 32'h0,        1'b1, 2'd3, 32'h0000007F, 32'h00010010},
    {6'b000000, 32'hECE0FF80, 1'b0, 2'd0, 32'h0,        32'h00010000},
    {6'b000000, 32'h0,        1'b1, 2'd1, 32'hFFFFFFFF, 32'h00010000},
    {6'b000000, 32'h0,        1'b1, 2'd3, 32'hFFFFFFFF, 32'h00000000}
  };
  localparam string VREQ [NV] = '{"R5", "R2", "R2", "R3", "R4", "R4", "R5", "R9", "R9", "R3"};

  logic clk = 0, rst_n = 0, reg_wr = 0, irq;
  logic [5:0] fifo_lvl = '0;
  logic [31:0] evt_pulse = '0, reg_wdata = '0, reg_rdata;
  logic [1:0] reg_addr = '0;
  int checks = 0, fails = 0;

  irq_status_ctrl dut_i (.clk(clk), .rst_n(rst_n), .fifo_lvl(fifo_lvl), .evt_pulse(evt_pulse),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, string req, logic [31:0] exp);
    reg_addr = a; #1; chk(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic pulse(logic [31:0] e);
    @(negedge clk); evt_pulse = e;
    @(posedge clk); #1 evt_pulse = '0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rd(2'd0, "R1", 0); rd(2'd1, "R1", 0); rd(2'd2, "R1", 0); chk("R1", irq, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fifo_lvl = VEC[i][104:99]; evt_pulse = VEC[i][98:67];
      reg_wr = VEC[i][66]; reg_addr = VEC[i][65:64]; reg_wdata = VEC[i][63:32];
      @(posedge clk); #1;
      reg_wr = 0; evt_pulse = '0;
      rd(2'd1, VREQ[i], VEC[i][31:0]);
    end

    wr(2'd0, 32'hFFFFFFFF);
    rd(2'd0, "R6", 32'h1FFFFFFF);
    wr(2'd0, 32'h0);
    pulse(32'h00080000);
    @(posedge clk); #1;
    chk("R8", irq, 0); rd(2'd2, "R7", 0); rd(2'd1, "R2", 32'h00080000);
    wr(2'd0, 32'h00080004);
    chk("R8", irq, 0); rd(2'd2, "R7", 32'h00080000);
    @(posedge clk); #1 chk("R8", irq, 1);
    wr(2'd3, 32'h00080000);
    rd(2'd2, "R3", 0); chk("R8", irq, 1);
    @(posedge clk); #1 chk("R8", irq, 0);
    @(negedge clk); fifo_lvl = 6'b000100;
    @(posedge clk); #1 rd(2'd2, "R7", 32'h4); chk("R8", irq, 0);
    @(posedge clk); #1 chk("R8", irq, 1);
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd0, "R9", 32'h00080004);
    rd(2'd3, "R9", 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule